// File: doc/BRIEF.md
# External Interrupt Detection Controller

This block watches a set of external interrupt pins and latches one pending flag per pin whenever that pin's programmed trigger condition occurs. Each pin passes through a synchronizer before detection. Software picks each pin's trigger through a 4-bit configuration nibble. Setting bit 3 of the nibble enables the pin. Bits 2:0 select the trigger: rising edge, falling edge, either edge, high level or low level. Three spare codes repeat the falling, either-edge and high-level behaviours.

The per-pin interrupt request is the pending flag gated by the pin's enable. Software removes a flag by writing a 1 to that pin's bit in a clear register. The clear bits are pulses and never store a value. A read-only status word shows every pending flag. Only some pin positions are built. Positions 3 and 6 are left out: their configuration bits read as zero, their clear bits do nothing, and they never raise a request.

The register interface is synchronous with word addressing. A write lands on the rising clock edge while `reg_we` is high. Read data is combinational from `reg_addr`.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0x0000 and `irq_out` is zero, so all pins start disabled with the rising-edge trigger selected.
- R2: Configuration words sit at word addresses 0, 1 and 2. Pin n uses word n/4, bits 4*(n%4)+3 down to 4*(n%4). Bit 3 of the nibble is the enable. A pin whose enable is 0 never sets its pending flag and never drives `irq_out`.
- R3: Trigger code 000 (rising edge) sets the pending flag on the third rising clock edge after the pin goes from 0 to 1, and not before that edge. A falling transition leaves the flag unchanged.
- R4: Codes 001 and 101 set the flag on a 1-to-0 transition only.
- R5: Codes 010 and 110 set the flag on either transition.
- R6: Codes 011 and 111 set the flag on every cycle that the synchronized pin is 1. A clear written while the pin stays high therefore leaves the flag set. The flag stays set after the pin drops.
- R7: Code 100 sets the flag on every cycle that the synchronized pin is 0.
- R8: Writing 1 to bit n of the clear register at word address 4 removes pin n's flag at that write's clock edge. That register always reads 0x0000.
- R9: Pin positions 3 and 6 are not built. Their configuration nibbles read as zero and they never raise `irq_out`. Clear bits 3, 6 and 15:9 have no effect on any flag.
- R10: When a trigger event and a clear for the same pin fall on the same clock edge, the flag ends up set.
- R11: The status word at word address 4+1 = 5 returns pending flag n in bit n. `irq_out[n]` is the flag ANDed with the enable, so disabling a pin masks its request without losing its flag.
- R12: Word address 2 holds only pin 8, in bits 3:0. Bits 15:4 of that word read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 9 | External interrupt pins, asynchronous |
| reg_addr | input | 3 | Register word address |
| reg_we | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| irq_out | output | 9 | Masked per-pin interrupt requests |

## Verification
A pin change reaches the pending flag on the third rising edge after it is driven: two edges go through the synchronizer and the third latches the flag. In the rising-edge test the bench checks one negative edge early that the flag is still clear, then checks again after the third edge that it is set. Clears and configuration writes take effect on the single edge of the write, and the bench samples straight after that edge. Low-level detection on an already-low pin is the one case timed from the configuration write: the flag appears one edge after it. All inputs are driven and all outputs sampled on falling edges, so no check races a rising edge.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

   typedef enum logic [2:0] {
      TRIG_RISE = 3'b000,
      TRIG_FALL = 3'b001,
      TRIG_BOTH = 3'b010,
      TRIG_HIGH = 3'b011,
      TRIG_LOW  = 3'b100
   } trig_e;

   localparam int unsigned CFG_LINES_PER_WORD = 4;
   localparam int unsigned ADR_CLEAR          = 4;
   localparam int unsigned ADR_STATUS         = 5;

   // Spare codes 101/110/111 fold onto 001/010/011.
   function automatic trig_e canon_trig(input logic [2:0] code);
      if (code == 3'b100) return TRIG_LOW;
      return trig_e'({1'b0, code[1:0]});
   endfunction

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
   parameter int WIDTH  = 9,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= '0;
      else        chain_q[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[s] <= '0;
         else        chain_q[s] <= chain_q[s-1];
      end
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/eirq_line.sv
module eirq_line
   import eirq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       din,
   input  logic       en,
   input  logic [2:0] mode,
   input  logic       clr,
   output logic       pend,
   output logic       hit
);

   logic  prev_q;
   logic  pend_q;
   logic  rise;
   logic  fall;
   logic  cond;
   trig_e trig;

   assign trig = canon_trig(mode);
   assign rise = din & ~prev_q;
   assign fall = ~din & prev_q;

   always_comb begin
      unique case (trig)
         TRIG_RISE: cond = rise;
         TRIG_FALL: cond = fall;
         TRIG_BOTH: cond = rise | fall;
         TRIG_HIGH: cond = din;
         TRIG_LOW:  cond = ~din;
         default:   cond = 1'b0;
      endcase
   end

   assign hit = en & cond;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         prev_q <= din;
         if (hit)      pend_q <= 1'b1;
         else if (clr) pend_q <= 1'b0;
      end
   end

   assign pend = pend_q;

endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
   import eirq_pkg::*;
#(
   parameter int                   NUM_LINES = 9,
   parameter int                   ADDR_W    = 3,
   parameter int                   DATA_W    = 16,
   parameter logic [NUM_LINES-1:0] IMPL_MASK = '1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ADDR_W-1:0]         reg_addr,
   input  logic                      reg_we,
   input  logic [DATA_W-1:0]         reg_wdata,
   output logic [DATA_W-1:0]         reg_rdata,
   input  logic [NUM_LINES-1:0]      pend_in,
   output logic [NUM_LINES-1:0]      line_en,
   output logic [NUM_LINES-1:0][2:0] line_mode,
   output logic [NUM_LINES-1:0]      clr_pulse
);

   localparam int                NIB       = 4;
   localparam logic [ADDR_W-1:0] A_CLEAR   = ADDR_W'(ADR_CLEAR);
   localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(ADR_STATUS);

   logic [NUM_LINES-1:0][NIB-1:0] cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (reg_we) begin
         for (int n = 0; n < NUM_LINES; n++) begin
            if (reg_addr == ADDR_W'(n / CFG_LINES_PER_WORD))
               cfg_q[n] <= IMPL_MASK[n]
                  ? reg_wdata[NIB*(n % CFG_LINES_PER_WORD) +: NIB] : '0;
         end
      end
   end

   for (genvar n = 0; n < NUM_LINES; n++) begin : g_fields
      assign line_en[n]   = cfg_q[n][NIB-1];
      assign line_mode[n] = cfg_q[n][NIB-2:0];
   end

   assign clr_pulse = (reg_we && reg_addr == A_CLEAR)
                    ? (reg_wdata[NUM_LINES-1:0] & IMPL_MASK) : '0;

   always_comb begin
      reg_rdata = '0;
      for (int n = 0; n < NUM_LINES; n++) begin
         if (reg_addr == ADDR_W'(n / CFG_LINES_PER_WORD))
            reg_rdata[NIB*(n % CFG_LINES_PER_WORD) +: NIB] = cfg_q[n];
      end
      if (reg_addr == A_STATUS) reg_rdata[NUM_LINES-1:0] = pend_in;
   end

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
   import eirq_pkg::*;
#(
   parameter int                   NUM_LINES   = 9,
   parameter int                   ADDR_W      = 3,
   parameter int                   DATA_W      = 16,
   parameter int                   SYNC_STAGES = 2,
   parameter logic [NUM_LINES-1:0] IMPL_MASK   = NUM_LINES'(16'h01B7)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_in,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic                 reg_we,
   input  logic [DATA_W-1:0]    reg_wdata,
   output logic [DATA_W-1:0]    reg_rdata,
   output logic [NUM_LINES-1:0] irq_out
);

   localparam int CFG_WORDS = (NUM_LINES + CFG_LINES_PER_WORD - 1) / CFG_LINES_PER_WORD;

   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("ext_irq_ctrl: SYNC_STAGES must be at least 2");
   end
   if (NUM_LINES < 1 || NUM_LINES > DATA_W) begin : g_chk_lines
      $error("ext_irq_ctrl: NUM_LINES must be 1..DATA_W");
   end
   if (DATA_W != 16) begin : g_chk_data
      $error("ext_irq_ctrl: DATA_W must be 16");
   end
   if (CFG_WORDS > int'(ADR_CLEAR) || (1 << ADDR_W) <= int'(ADR_STATUS)) begin : g_chk_map
      $error("ext_irq_ctrl: register map does not fit ADDR_W");
   end

   logic [NUM_LINES-1:0]      sync_q;
   logic [NUM_LINES-1:0]      line_en;
   logic [NUM_LINES-1:0][2:0] line_mode;
   logic [NUM_LINES-1:0]      clr_pulse;
   logic [NUM_LINES-1:0]      pend;
   logic [NUM_LINES-1:0]      set_ev;
   logic                      unused_sink;

   eirq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (irq_in),
      .q     (sync_q)
   );

   eirq_regs #(
      .NUM_LINES (NUM_LINES),
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .IMPL_MASK (IMPL_MASK)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_we    (reg_we),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .pend_in   (pend),
      .line_en   (line_en),
      .line_mode (line_mode),
      .clr_pulse (clr_pulse)
   );

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      if (IMPL_MASK[i]) begin : g_live
         eirq_line u_line (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (sync_q[i]),
            .en    (line_en[i]),
            .mode  (line_mode[i]),
            .clr   (clr_pulse[i]),
            .pend  (pend[i]),
            .hit   (set_ev[i])
         );
      end else begin : g_absent
         assign pend[i]   = 1'b0;
         assign set_ev[i] = 1'b0;
      end
   end

   assign unused_sink = ^{sync_q, line_mode, clr_pulse, set_ev};

   assign irq_out = pend & line_en;

endmodule

// File: rtl/ext_irq_ctrl_checker.sv
module ext_irq_ctrl_checker
   import eirq_pkg::*;
#(
   parameter int NUM_LINES = 9,
   parameter int ADDR_W    = 3,
   parameter int DATA_W    = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [ADDR_W-1:0]    reg_addr,
   input logic [DATA_W-1:0]    reg_rdata,
   input logic [NUM_LINES-1:0] irq_out,
   input logic [NUM_LINES-1:0] pend,
   input logic [NUM_LINES-1:0] set_ev,
   input logic [NUM_LINES-1:0] line_en,
   input logic [NUM_LINES-1:0] clr_pulse
);

   localparam logic [ADDR_W-1:0] A_CLEAR = ADDR_W'(ADR_CLEAR);

   p_clr_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == A_CLEAR) |-> (reg_rdata == '0));

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_ln
      p_irq_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
         irq_out[i] |-> line_en[i]);

      p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
         set_ev[i] |=> pend[i]);

      p_clear_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_pulse[i] && !set_ev[i]) |=> !pend[i]);

      p_pend_has_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pend[i]) |-> $past(set_ev[i]));
   end

endmodule

bind ext_irq_ctrl ext_irq_ctrl_checker #(
   .NUM_LINES (NUM_LINES),
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W)
) u_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_rdata (reg_rdata),
   .irq_out   (irq_out),
   .pend      (pend),
   .set_ev    (set_ev),
   .line_en   (line_en),
   .clr_pulse (clr_pulse)
);

// File: tb/ext_irq_ctrl_bench.sv
module ext_irq_ctrl_bench;

   localparam int CLK_NS = 4;
   localparam logic [2:0] A_STAT = 3'd5;
   localparam logic [2:0] A_CLR  = 3'd4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [8:0]  irq_in = '0;
   logic [2:0]  reg_addr = '0;
   logic        reg_we = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [8:0]  irq_out;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_NS/2) clk = ~clk;

   ext_irq_ctrl u_ext_irq_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_in    (irq_in),
      .reg_addr  (reg_addr),
      .reg_we    (reg_we),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq_out   (irq_out)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
      end
   endtask

   task automatic rd_chk(input string req, input logic [2:0] a, input logic [15:0] exp);
      reg_addr = a;
      #1;
      check(req, reg_rdata, exp);
   endtask

   task automatic irq_chk(input string req, input logic [8:0] exp);
      check(req, {7'd0, irq_out}, {7'd0, exp});
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_addr  = a;
      reg_we    = 1'b1;
      reg_wdata = d;
      @(negedge clk);
      reg_we    = 1'b0;
      reg_wdata = '0;
   endtask

   task automatic pin(input int n, input logic v);
      @(negedge clk);
      irq_in[n] = v;
   endtask

   task automatic cyc(input int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic t_reset;
      rd_chk("R1 cfg0", 3'd0, 16'h0000);
      rd_chk("R1 cfg1", 3'd1, 16'h0000);
      rd_chk("R1 cfg2", 3'd2, 16'h0000);
      rd_chk("R1 clear", A_CLR, 16'h0000);
      rd_chk("R1 status", A_STAT, 16'h0000);
      irq_chk("R1 irq", 9'h000);
   endtask

   task automatic t_layout;
      wr(3'd0, 16'hFFFF);
      rd_chk("R2 R9 cfg0 readback", 3'd0, 16'h0FFF);
      wr(3'd1, 16'hFFFF);
      rd_chk("R2 R9 cfg1 readback", 3'd1, 16'hF0FF);
      wr(3'd2, 16'hFFFF);
      rd_chk("R12 cfg2 readback", 3'd2, 16'h000F);
      irq_chk("R6 no level present", 9'h000);
      wr(3'd0, 16'h0000); wr(3'd1, 16'h0000); wr(3'd2, 16'h0000);
      wr(3'd0, 16'h0007);           // line 0 high-level, disabled
      pin(0, 1'b1); cyc(3);
      rd_chk("R2 disabled no pending", A_STAT, 16'h0000);
      irq_chk("R2 disabled no irq", 9'h000);
      pin(0, 1'b0); cyc(3);
      wr(3'd0, 16'h0000);
   endtask

   task automatic t_rise;
      wr(3'd0, 16'h0008);
      pin(0, 1'b1); cyc(2);
      irq_chk("R3 not before third edge", 9'h000);
      cyc(1);
      irq_chk("R3 set on third edge", 9'h001);
      rd_chk("R3 R11 status", A_STAT, 16'h0001);
      wr(A_CLR, 16'h0001);
      rd_chk("R8 cleared", A_STAT, 16'h0000);
      rd_chk("R8 clear reads zero", A_CLR, 16'h0000);
      pin(0, 1'b0); cyc(4);
      irq_chk("R3 falling ignored", 9'h000);
      wr(3'd0, 16'h0000);
   endtask

   task automatic t_fall;
      logic [15:0] cfgs [2] = '{16'h0090, 16'h00D0};
      foreach (cfgs[k]) begin
         wr(3'd0, cfgs[k]);
         pin(1, 1'b1); cyc(3);
         rd_chk("R4 rise ignored", A_STAT, 16'h0000);
         pin(1, 1'b0); cyc(3);
         rd_chk("R4 fall sets", A_STAT, 16'h0002);
         irq_chk("R4 irq", 9'h002);
         wr(A_CLR, 16'h0002);
      end
      wr(3'd0, 16'h0000);
   endtask

   task automatic t_both;
      logic [15:0] cfgs [2] = '{16'h0A00, 16'h0E00};
      foreach (cfgs[k]) begin
         wr(3'd0, cfgs[k]);
         pin(2, 1'b1); cyc(3);
         rd_chk("R5 rise sets", A_STAT, 16'h0004);
         wr(A_CLR, 16'h0004);
         rd_chk("R5 R8 cleared", A_STAT, 16'h0000);
         pin(2, 1'b0); cyc(3);
         rd_chk("R5 fall sets", A_STAT, 16'h0004);
         wr(A_CLR, 16'h0004);
      end
      wr(3'd0, 16'h0000);
   endtask

   task automatic t_high;
      logic [15:0] cfgs [2] = '{16'h000B, 16'h000F};
      foreach (cfgs[k]) begin
         wr(3'd1, cfgs[k]);
         rd_chk("R6 low input idle", A_STAT, 16'h0000);
         pin(4, 1'b1); cyc(3);
         rd_chk("R6 level sets", A_STAT, 16'h0010);
         irq_chk("R6 irq", 9'h010);
         wr(A_CLR, 16'h0010);
         rd_chk("R6 clear overridden by level", A_STAT, 16'h0010);
         pin(4, 1'b0); cyc(3);
         rd_chk("R6 held after level drops", A_STAT, 16'h0010);
         wr(A_CLR, 16'h0010);
         rd_chk("R6 R8 cleared", A_STAT, 16'h0000);
      end
      wr(3'd1, 16'h0000);
   endtask

   task automatic t_low;
      wr(3'd1, 16'h00C0);
      cyc(1);
      rd_chk("R7 low level sets", A_STAT, 16'h0020);
      irq_chk("R7 irq", 9'h020);
      pin(5, 1'b1); cyc(3);
      wr(A_CLR, 16'h0020);
      rd_chk("R7 high input no set", A_STAT, 16'h0000);
      pin(5, 1'b0); cyc(3);
      rd_chk("R7 sets again on low", A_STAT, 16'h0020);
      wr(3'd1, 16'h0000);
      wr(A_CLR, 16'h0020);
      rd_chk("R7 R8 cleared", A_STAT, 16'h0000);
   endtask

   task automatic t_same_edge;
      wr(3'd1, 16'h8000);
      @(negedge clk);
      irq_in[7] = 1'b1;
      cyc(2);
      reg_addr  = A_CLR;
      reg_we    = 1'b1;
      reg_wdata = 16'h0080;
      @(negedge clk);
      reg_we    = 1'b0;
      reg_wdata = '0;
      rd_chk("R10 set beats clear", A_STAT, 16'h0080);
      wr(A_CLR, 16'h0080);
      rd_chk("R10 R8 later clear", A_STAT, 16'h0000);
      pin(7, 1'b0);
      wr(3'd1, 16'h0000);
   endtask

   task automatic t_unimpl;
      wr(3'd0, 16'h8000);
      rd_chk("R9 line3 nibble zero", 3'd0, 16'h0000);
      wr(3'd1, 16'h0800);
      rd_chk("R9 line6 nibble zero", 3'd1, 16'h0000);
      wr(3'd2, 16'h0008);
      pin(3, 1'b1); pin(6, 1'b1); pin(8, 1'b1); cyc(3);
      rd_chk("R9 only line8 pending", A_STAT, 16'h0100);
      irq_chk("R9 irq line8 only", 9'h100);
      wr(A_CLR, 16'hFE48);
      rd_chk("R9 reserved clear bits", A_STAT, 16'h0100);
      wr(A_CLR, 16'h0100);
      rd_chk("R9 R8 line8 cleared", A_STAT, 16'h0000);
      pin(3, 1'b0); pin(6, 1'b0); pin(8, 1'b0);
      wr(3'd0, 16'h0000); wr(3'd1, 16'h0000); wr(3'd2, 16'h0000);
   endtask

   task automatic t_mask;
      wr(3'd0, 16'h0008);
      pin(0, 1'b1); cyc(3);
      irq_chk("R11 irq raised", 9'h001);
      wr(3'd0, 16'h0000);
      irq_chk("R11 disabled masks irq", 9'h000);
      rd_chk("R11 flag kept", A_STAT, 16'h0001);
      wr(3'd0, 16'h0008);
      irq_chk("R11 re-enable restores irq", 9'h001);
      wr(3'd0, 16'h0000);
      wr(A_CLR, 16'h0001);
      pin(0, 1'b0); pin(0, 1'b1); cyc(3);
      rd_chk("R2 no latch while disabled", A_STAT, 16'h0000);
      wr(3'd0, 16'h0008); cyc(3);
      irq_chk("R2 enable gives no stale edge", 9'h000);
      pin(0, 1'b0);
      wr(3'd0, 16'h0000);
   endtask

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      t_reset();
      t_layout();
      t_rise();
      t_fall();
      t_both();
      t_high();
      t_low();
      t_same_edge();
      t_unimpl();
      t_mask();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(CLK_NS * 150000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule